// File: doc/BRIEF.md
# Picture Frame Timing and Blanking Interrupt Generator

This block keeps the raster position for a tile-based picture processor. It counts dot clocks across each scanline and scanlines down each frame. From that position it decodes the visible picture area, the window in which the renderer is active, and a one-cycle marker at the top of every frame. Pixel generation and memory fetches are handled by other blocks, which use these outputs.

It also holds the vertical blanking flag that the CPU reads. The flag is set when the blanking lines begin. It is cleared on the pre-render line, or when the CPU reads the status register. The interrupt line to the CPU is the flag gated by a control bit, so the CPU can enable interrupts in the middle of blanking and still get one.

The default geometry is 341 dots per line and 262 lines per frame, with 240 visible lines. At a 5.37 MHz dot clock this gives close to 60 frames per second. Every output is taken straight from a flip-flop. The decodes are computed from the counters' next value, so each flag lines up with the position shown on the counter outputs in the same cycle.

Top module: `ppu_frame_timing`

## Requirements
- R1: `dot_o` counts 0, 1, …, DOTS-1 and advances by one on every clock; after DOTS-1 it returns to 0.
- R2: `line_o` advances by one in the cycle where `dot_o` wraps, and returns to 0 after LINES-1. Reset leaves dot 0, line 0, `vblank_o` = 0 and `nmi_o` = 0.
- R3: `visible_o` is 1 exactly when `dot_o` is in 1..VIS_DOTS and `line_o` is in 0..VIS_LINES-1.
- R4: `render_o` is 1 exactly when `line_o` is below VIS_LINES or equals the pre-render line (LINES-1), at every dot.
- R5: `frame_start_o` is 1 exactly when the counters show dot 0 of line 0, which gives one pulse per frame. This includes the cycle right after reset.
- R6: `vblank_o` becomes 1 in the cycle in which the counters show dot 1 of line VIS_LINES+1. It stays 1 until one of the clears in R7 or R8 happens.
- R7: `vblank_o` is 0 from the cycle in which the counters show dot 1 of the pre-render line.
- R8: When `stat_rd_i` is high at a clock edge, `vblank_o` is 0 in the next cycle. The exception is when that same edge moves the counters to dot 1 of line VIS_LINES+1; the set takes priority and `vblank_o` is 1. A read while the flag is 0 has no effect.
- R9: In each cycle, `nmi_o` equals `vblank_o` AND the value `nmi_en_i` had at the previous clock edge. Raising the enable during blanking raises `nmi_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_en_i | input | 1 | Interrupt enable control bit (level) |
| stat_rd_i | input | 1 | One-cycle strobe for a CPU status read |
| dot_o | output | DOT_W | Dot position within the line |
| line_o | output | LINE_W | Line position within the frame |
| visible_o | output | 1 | Current dot is in the visible picture |
| render_o | output | 1 | Current line is in the render window |
| frame_start_o | output | 1 | First dot of a frame |
| vblank_o | output | 1 | Vertical blanking status flag |
| nmi_o | output | 1 | Interrupt request to the CPU |

## Verification
Every output is a single register, fed from the look-ahead of the counters. So after n edges since reset, all outputs must match position n: dot n mod DOTS and line (n div DOTS) mod LINES. The bench computes that position arithmetically at the falling edge and compares every output there. Read strobes and enable changes are driven at the falling edge, and their effect is due exactly one rising edge later. The bench therefore updates its flag and interrupt model at that edge, including the case where a read lands on the same edge as the set. The bench uses a reduced 20 × 12 geometry so that it can sweep many whole frames with every combination of read and enable.

// File: rtl/ppu_timing_pkg.sv
package ppu_timing_pkg;

  // Region decode bundle, registered together.
  typedef struct packed {
    logic visible;
    logic render;
    logic frame_start;
  } region_t;

  localparam region_t REGION_RESET = '{visible: 1'b0, render: 1'b1, frame_start: 1'b1};

endpackage

// File: rtl/ppu_pos_counter.sv
module ppu_pos_counter #(
  parameter int DOTS   = 341,
  parameter int LINES  = 262,
  parameter int DOT_W  = $clog2(DOTS),
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DOT_W-1:0]  dot_q,
  output logic [LINE_W-1:0] line_q,
  output logic [DOT_W-1:0]  dot_nxt,
  output logic [LINE_W-1:0] line_nxt
);

  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  logic dot_wrap;

  always_comb begin
    dot_wrap = (dot_q == DOT_LAST);
    dot_nxt  = dot_wrap ? '0 : dot_q + DOT_W'(1);
    if (!dot_wrap)
      line_nxt = line_q;
    else if (line_q == LINE_LAST)
      line_nxt = '0;
    else
      line_nxt = line_q + LINE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q  <= '0;
      line_q <= '0;
    end else begin
      dot_q  <= dot_nxt;
      line_q <= line_nxt;
    end
  end

  a_r1_dot_wraps: assert property (@(posedge clk) disable iff (rst)
    dot_q == DOT_LAST |=> dot_q == '0);
  a_r1_dot_steps: assert property (@(posedge clk) disable iff (rst)
    dot_q != DOT_LAST |=> dot_q == $past(dot_q) + DOT_W'(1));
  a_r2_line_holds: assert property (@(posedge clk) disable iff (rst)
    dot_q != DOT_LAST |=> $stable(line_q));
  a_r2_line_range: assert property (@(posedge clk) disable iff (rst)
    line_q <= LINE_LAST);

endmodule

// File: rtl/ppu_region_decode.sv
module ppu_region_decode
  import ppu_timing_pkg::*;
#(
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VIS_DOTS  = 256,
  parameter int VIS_LINES = 240,
  parameter int DOT_W     = $clog2(DOTS),
  parameter int LINE_W    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DOT_W-1:0]  dot_nxt,
  input  logic [LINE_W-1:0] line_nxt,
  output region_t           region_q
);

  localparam logic [LINE_W-1:0] PRE_LINE = LINE_W'(LINES - 1);

  region_t region_d;
  logic    line_vis;

  always_comb begin
    line_vis             = (int'(line_nxt) < VIS_LINES);
    region_d.visible     = line_vis && (dot_nxt != '0) && (int'(dot_nxt) <= VIS_DOTS);
    region_d.render      = line_vis || (line_nxt == PRE_LINE);
    region_d.frame_start = (dot_nxt == '0) && (line_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) region_q <= REGION_RESET;
    else     region_q <= region_d;
  end

  a_r3_visible_in_render: assert property (@(posedge clk) disable iff (rst)
    region_q.visible |-> region_q.render);
  a_r5_single_start: assert property (@(posedge clk) disable iff (rst)
    region_q.frame_start |=> !region_q.frame_start);

endmodule

// File: rtl/ppu_vblank_ctrl.sv
module ppu_vblank_ctrl #(
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VIS_LINES = 240,
  parameter int DOT_W     = $clog2(DOTS),
  parameter int LINE_W    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DOT_W-1:0]  dot_nxt,
  input  logic [LINE_W-1:0] line_nxt,
  input  logic              stat_rd,
  input  logic              nmi_en,
  output logic              vblank_q,
  output logic              nmi_q
);

  localparam logic [LINE_W-1:0] SET_LINE = LINE_W'(VIS_LINES + 1);
  localparam logic [LINE_W-1:0] PRE_LINE = LINE_W'(LINES - 1);
  localparam logic [DOT_W-1:0]  EDGE_DOT = DOT_W'(1);

  logic set_ev, clr_ev, flag_d;

  always_comb begin
    set_ev = (dot_nxt == EDGE_DOT) && (line_nxt == SET_LINE);
    clr_ev = (dot_nxt == EDGE_DOT) && (line_nxt == PRE_LINE);
    if (set_ev)                flag_d = 1'b1;
    else if (clr_ev || stat_rd) flag_d = 1'b0;
    else                       flag_d = vblank_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vblank_q <= 1'b0;
      nmi_q    <= 1'b0;
    end else begin
      vblank_q <= flag_d;
      nmi_q    <= flag_d & nmi_en;
    end
  end

  a_r9_nmi_needs_flag: assert property (@(posedge clk) disable iff (rst)
    nmi_q |-> vblank_q);
  a_r9_nmi_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_q) |-> $past(nmi_en));
  a_r9_enable_in_blank: assert property (@(posedge clk) disable iff (rst)
    nmi_en && vblank_q && !stat_rd && !clr_ev |=> nmi_q);

endmodule

// File: rtl/ppu_frame_timing.sv
module ppu_frame_timing
  import ppu_timing_pkg::*;
#(
  parameter int DOTS      = 341,
  parameter int LINES     = 262,
  parameter int VIS_DOTS  = 256,
  parameter int VIS_LINES = 240,
  parameter int DOT_W     = $clog2(DOTS),
  parameter int LINE_W    = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_en_i,
  input  logic              stat_rd_i,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              visible_o,
  output logic              render_o,
  output logic              frame_start_o,
  output logic              vblank_o,
  output logic              nmi_o
);

  localparam logic [LINE_W-1:0] SET_LINE = LINE_W'(VIS_LINES + 1);
  localparam logic [LINE_W-1:0] PRE_LINE = LINE_W'(LINES - 1);

  logic [DOT_W-1:0]  dot_nxt;
  logic [LINE_W-1:0] line_nxt;
  region_t           region;

  ppu_pos_counter #(
    .DOTS(DOTS), .LINES(LINES), .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_pos (
    .clk(clk), .rst(rst),
    .dot_q(dot_o), .line_q(line_o),
    .dot_nxt(dot_nxt), .line_nxt(line_nxt)
  );

  ppu_region_decode #(
    .DOTS(DOTS), .LINES(LINES), .VIS_DOTS(VIS_DOTS), .VIS_LINES(VIS_LINES),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_region (
    .clk(clk), .rst(rst),
    .dot_nxt(dot_nxt), .line_nxt(line_nxt),
    .region_q(region)
  );

  ppu_vblank_ctrl #(
    .DOTS(DOTS), .LINES(LINES), .VIS_LINES(VIS_LINES),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_vbl (
    .clk(clk), .rst(rst),
    .dot_nxt(dot_nxt), .line_nxt(line_nxt),
    .stat_rd(stat_rd_i), .nmi_en(nmi_en_i),
    .vblank_q(vblank_o), .nmi_q(nmi_o)
  );

  assign visible_o     = region.visible;
  assign render_o      = region.render;
  assign frame_start_o = region.frame_start;

  a_r5_start_position: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> (dot_o == '0 && line_o == '0));
  a_r6_set_point: assert property (@(posedge clk) disable iff (rst)
    (dot_o == DOT_W'(1) && line_o == SET_LINE) |-> vblank_o);
  a_r7_pre_clear: assert property (@(posedge clk) disable iff (rst)
    (dot_o == DOT_W'(1) && line_o == PRE_LINE) |-> !vblank_o);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    stat_rd_i && !(dot_o == '0 && line_o == SET_LINE) |=> !vblank_o);
  a_r3_visible_lines: assert property (@(posedge clk) disable iff (rst)
    visible_o |-> int'(line_o) < VIS_LINES);

endmodule

// File: tb/ppu_frame_timing_tb.sv
module ppu_frame_timing_tb;

  localparam int DOTS      = 20;
  localparam int LINES     = 12;
  localparam int VIS_DOTS  = 12;
  localparam int VIS_LINES = 8;
  localparam int DOT_W     = $clog2(DOTS);
  localparam int LINE_W    = $clog2(LINES);
  localparam int FRAME     = DOTS * LINES;
  localparam int SET_LINE  = VIS_LINES + 1;
  localparam int PRE_LINE  = LINES - 1;
  localparam int NCYC      = 7 * FRAME;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              nmi_en_i = 1'b0;
  logic              stat_rd_i = 1'b0;
  logic [DOT_W-1:0]  dot_o;
  logic [LINE_W-1:0] line_o;
  logic              visible_o, render_o, frame_start_o, vblank_o, nmi_o;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  ppu_frame_timing #(
    .DOTS(DOTS), .LINES(LINES), .VIS_DOTS(VIS_DOTS), .VIS_LINES(VIS_LINES),
    .DOT_W(DOT_W), .LINE_W(LINE_W)
  ) u_dut (
    .clk(clk), .rst(rst), .nmi_en_i(nmi_en_i), .stat_rd_i(stat_rd_i),
    .dot_o(dot_o), .line_o(line_o), .visible_o(visible_o), .render_o(render_o),
    .frame_start_o(frame_start_o), .vblank_o(vblank_o), .nmi_o(nmi_o)
  );

  task automatic chk(input string tag, input int act, input int exp, input int n);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, n, act, exp);
    end
  endtask

  function automatic int pos_dot(input int n);
    return n % DOTS;
  endfunction

  function automatic int pos_line(input int n);
    return (n / DOTS) % LINES;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int  exp_flag;
    int  exp_nmi;
    int  d, l, nd, nl;
    int  saw_nmi_rise;
    saw_nmi_rise = 0;
    exp_flag = 0;
    exp_nmi  = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < NCYC; n++) begin
      d = pos_dot(n);
      l = pos_line(n);
      // R1 R2: position; first pass is the reset state
      chk(n == 0 ? "R2 reset dot" : "R1 dot", int'(dot_o), d, n);
      chk(n == 0 ? "R2 reset line" : "R2 line", int'(line_o), l, n);
      chk("R3 visible", int'(visible_o),
          int'(l < VIS_LINES && d >= 1 && d <= VIS_DOTS), n);
      chk("R4 render", int'(render_o), int'(l < VIS_LINES || l == PRE_LINE), n);
      chk("R5 frame_start", int'(frame_start_o), int'(d == 0 && l == 0), n);
      chk(n == 0 ? "R2 reset vblank" : "R6 R7 R8 vblank", int'(vblank_o), exp_flag, n);
      chk(n == 0 ? "R2 reset nmi" : "R9 nmi", int'(nmi_o), exp_nmi, n);
      if (d == 1 && l == SET_LINE)
        chk("R6 set point", int'(vblank_o), 1, n);
      if (d == 1 && l == PRE_LINE)
        chk("R7 pre-render clear", int'(vblank_o), 0, n);

      nd = pos_dot(n + 1);
      nl = pos_line(n + 1);
      if (n < 2 * FRAME) begin
        nmi_en_i  = 1'b1;
        stat_rd_i = 1'b0;
      end else if (n < 4 * FRAME) begin
        nmi_en_i  = 1'b1;
        // R8: reads at scattered points, plus one on the set edge in frame 2
        stat_rd_i = ((n % 23) == 7) ||
                    ((n / FRAME) == 2 && nd == 1 && nl == SET_LINE);
      end else begin
        // R9: enable toggling, including during blanking; sparse reads
        nmi_en_i  = ((n / 17) % 2) == 1;
        stat_rd_i = (n % 41) == 3;
      end

      if (nd == 1 && nl == SET_LINE)          exp_flag = 1;
      else if ((nd == 1 && nl == PRE_LINE) || stat_rd_i) exp_flag = 0;
      if (exp_nmi == 0 && (exp_flag & int'(nmi_en_i)) == 1) saw_nmi_rise++;
      exp_nmi = exp_flag & int'(nmi_en_i);

      @(posedge clk);
      @(negedge clk);
    end
    chk("R9 nmi rises observed", int'(saw_nmi_rise > 3), 1, NCYC);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule